// File: doc/BRIEF.md
# Spread-Spectrum Phase Rotation Controller

This block spreads a clock's spectrum without touching the PLL. It drives the phase select code of a 64-phase interpolator and keeps moving that code in one direction. The speed of the rotation sets how far the output frequency falls below nominal. A triangular offset profile sets that speed. Each profile update adds or removes a fixed slope from a 24-bit fractional offset. The offset rises from zero to a peak and falls back to zero, and then the cycle repeats. The spread is therefore downward only.

Each clock cycle, a sigma-delta modulator turns the fractional offset into an integer step of the phase code. The modulator can run as a first-order stage or as a two-stage cascade (MASH 1-1). The second-order mode pushes the dither noise to higher frequencies. The phase code wraps modulo 64.

The slope and the half-period count are captured only while the spread is disabled, so a triangle always closes exactly.

Sizing example at 125 MHz with 64 phases: a depth of 5000 ppm is a peak offset of about 0.32 phase steps per cycle, which is about 5.37e6 in 24-bit units. A 30 kHz triangle lasts about 4167 cycles. With the default prescaler of 4, the half-period is therefore about 520 profile updates and the slope is about 10300.

Top module: `ssc_phase_rotator`

## Requirements
- R1: After reset, `phase_idx` is 0 and `freq_falling` is 1 (the triangle starts at zero offset, heading down in frequency).
- R2: While `spread_en` is 0, `phase_idx` holds its value, `freq_falling` is 1, and the offset, the modulator accumulators and the profile counter are cleared. Re-enabling restarts the triangle from zero offset.
- R3: While rising, the offset grows by exactly the slope on each profile update and never wraps, provided slope × half-period is at most 2^24−1. A peak of 2^24−1 is reached without loss.
- R4: A profile update occurs once every TICK_DIV enabled cycles (default 4). `freq_falling` stays 1 for H updates and 0 for H updates, where H is the half-period setting. A setting of 0 acts as 1.
- R5: Over each full triangle period the net offset change is zero, and the offset is exactly 0 whenever `freq_falling` rises.
- R6: With `order_sel`=0 (first order), the phase advances each enabled cycle by the carry out of a 24-bit accumulator that adds the offset. The step is 0 or +1.
- R7: With `order_sel`=1 (second order), a second 24-bit accumulator adds the first accumulator's new sum. The step is c1 + c2 − c2 of the previous cycle, which lies in −1..+2. In first order, the second stage is held at zero.
- R8: `phase_idx` wraps modulo 64: it goes from 63 to 0 when stepping up, and from 0 to 63 when stepping down.
- R9: Changes to `slope_cfg` and `half_cfg` while `spread_en` is 1 have no effect until the spread has been disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Spread enable; 0 holds the phase and clears the profile |
| order_sel | input | 1 | Modulator order: 0 first, 1 second (MASH 1-1) |
| slope_cfg | input | 24 | Offset change per profile update (24-bit fraction of a phase step per cycle) |
| half_cfg | input | 16 | Profile updates per triangle half (0 treated as 1) |
| phase_idx | output | 6 | Interpolator phase select code |
| freq_falling | output | 1 | 1 while the offset rises (frequency going down), 0 while it falls |

## Verification
The bench uses the closed form of the first-order phase advance over whole triangle periods, which is floor(TICK_DIV·slope·H²·P / 2^24). A profile that failed to return exactly to zero, or an offset that wrapped at a peak of 2^24−1, would drift away from this value. It times the apex toggles for H=7 and H=0, which exposes an off-by-one in the apex compare or an unmapped zero setting. It reprograms the settings mid-ramp; a design without the captured copies would change the toggle spacing. It drops the enable in second-order mode; a design that kept stepping, or that did not restart downward, would move the phase or leave the flag low. Random runs that mix orders, check every cycle against a cycle model and watch the per-cycle step set and the 63/0 wraps catch a MASH stage that subtracts the wrong carry.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // signed integer phase step produced by the modulator (-1..+2 fits in 3 bits)
  typedef logic signed [2:0] step_t;
endpackage

// File: rtl/ssc_tick_gen.sv
module ssc_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = en;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q, pre_n;

      always_comb begin
        pre_n = pre_q;
        if (!en)               pre_n = '0;
        else if (pre_q == LAST) pre_n = '0;
        else                   pre_n = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_n;
      end

      assign tick = en && (pre_q == LAST);

      // R4: prescaler never leaves its range
      a_r4_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile #(
  parameter int unsigned FRAC_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [FRAC_W-1:0] slope_in,
  input  logic [CNT_W-1:0]  half_in,
  output logic [FRAC_W-1:0] ofs,
  output logic              rising
);
  logic [FRAC_W-1:0] slope_q, slope_n;
  logic [CNT_W-1:0]  half_q, half_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [FRAC_W-1:0] ofs_q, ofs_n;
  logic              dir_q, dir_n;
  logic [CNT_W:0]    cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    slope_n = slope_q;
    half_n  = half_q;
    cnt_n   = cnt_q;
    ofs_n   = ofs_q;
    dir_n   = dir_q;
    if (!en) begin
      // settings are captured only while idle (R9); profile restarts (R2)
      slope_n = slope_in;
      half_n  = (half_in == '0) ? CNT_W'(1) : half_in;
      cnt_n   = '0;
      ofs_n   = '0;
      dir_n   = 1'b1;
    end else if (tick) begin
      if (dir_q) begin
        cnt_n = cnt_inc[CNT_W-1:0];
        ofs_n = ofs_q + slope_q;
        if (cnt_inc >= {1'b0, half_q}) dir_n = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
        ofs_n = ofs_q - slope_q;
        if (cnt_q == CNT_W'(1)) dir_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slope_q <= '0;
      half_q  <= CNT_W'(1);
      cnt_q   <= '0;
      ofs_q   <= '0;
      dir_q   <= 1'b1;
    end else begin
      slope_q <= slope_n;
      half_q  <= half_n;
      cnt_q   <= cnt_n;
      ofs_q   <= ofs_n;
      dir_q   <= dir_n;
    end
  end

  assign ofs    = ofs_q;
  assign rising = dir_q;

  // R3: a rising update never wraps the offset
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && dir_q) |=> (ofs_q >= $past(ofs_q)));
  // R5: the offset is back at zero whenever the direction turns downward again
  a_r5_trough_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_q) |-> (ofs_q == '0));
  // R4: the update counter stays inside the captured half-period
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_q);
endmodule

// File: rtl/ssc_sdm.sv
module ssc_sdm
  import ssc_pkg::*;
#(
  parameter int unsigned FRAC_W    = 24,
  parameter int unsigned MAX_ORDER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              order2,
  input  logic [FRAC_W-1:0] ofs,
  output step_t             step
);
  logic [FRAC_W:0]   sum1;
  logic [FRAC_W-1:0] acc1_q, acc1_n;
  logic              c1;

  assign sum1   = {1'b0, acc1_q} + {1'b0, ofs};
  assign c1     = sum1[FRAC_W];
  assign acc1_n = en ? sum1[FRAC_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc1_q <= '0;
    else        acc1_q <= acc1_n;
  end

  generate
    if (MAX_ORDER >= 2) begin : g_mash
      logic [FRAC_W:0]   sum2;
      logic [FRAC_W-1:0] acc2_q, acc2_n;
      logic              c2, c2d_q, c2d_n, use2;

      assign sum2   = {1'b0, acc2_q} + {1'b0, sum1[FRAC_W-1:0]};
      assign c2     = sum2[FRAC_W];
      assign use2   = en && order2;
      assign acc2_n = use2 ? sum2[FRAC_W-1:0] : '0;
      assign c2d_n  = use2 ? c2 : 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc2_q <= '0;
          c2d_q  <= 1'b0;
        end else begin
          acc2_q <= acc2_n;
          c2d_q  <= c2d_n;
        end
      end

      always_comb begin
        if (order2)
          step = step_t'({2'b00, c1}) + step_t'({2'b00, c2}) - step_t'({2'b00, c2d_q});
        else
          step = step_t'({2'b00, c1});
      end

      // R7: in first order the second stage stays cleared
      a_r7_stage2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !order2 |=> (acc2_q == '0 && !c2d_q));
    end else begin : g_first
      assign step = step_t'({2'b00, c1});
    end
  endgenerate
endmodule

// File: rtl/ssc_phase_rotator.sv
module ssc_phase_rotator
  import ssc_pkg::*;
#(
  parameter int unsigned PH_W      = 6,
  parameter int unsigned FRAC_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TICK_DIV  = 4,
  parameter int unsigned MAX_ORDER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spread_en,
  input  logic              order_sel,
  input  logic [FRAC_W-1:0] slope_cfg,
  input  logic [CNT_W-1:0]  half_cfg,
  output logic [PH_W-1:0]   phase_idx,
  output logic              freq_falling
);
  localparam int unsigned EXT_W = PH_W - 3;

  logic              tick;
  logic [FRAC_W-1:0] ofs;
  step_t             step;
  logic [PH_W-1:0]   phase_q, phase_n, step_ext;

  ssc_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk (clk),
    .rst_n (rst_n),
    .en (spread_en),
    .tick (tick)
  );

  ssc_tri_profile #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) i_prof (
    .clk (clk),
    .rst_n (rst_n),
    .en (spread_en),
    .tick (tick),
    .slope_in (slope_cfg),
    .half_in (half_cfg),
    .ofs (ofs),
    .rising (freq_falling)
  );

  ssc_sdm #(.FRAC_W(FRAC_W), .MAX_ORDER(MAX_ORDER)) i_sdm (
    .clk (clk),
    .rst_n (rst_n),
    .en (spread_en),
    .order2 (order_sel),
    .ofs (ofs),
    .step (step)
  );

  assign step_ext = {{EXT_W{step[2]}}, step};

  always_comb begin
    phase_n = phase_q;
    if (spread_en) phase_n = phase_q + step_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  assign phase_idx = phase_q;

  // R2: disabled cycles leave the phase untouched and restart the profile downward
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_en |=> $stable(phase_q));
  a_r2_restart_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_en |=> freq_falling);
  // R6: first-order steps are 0 or +1
  a_r6_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_en && !order_sel) |=>
      (PH_W'(phase_q - $past(phase_q)) inside {PH_W'(0), PH_W'(1)}));
  // R7: second-order steps stay in -1..+2 (modulo the phase count, R8)
  a_r7_second_step: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_en && order_sel) |=>
      (PH_W'(phase_q - $past(phase_q)) inside {PH_W'(0), PH_W'(1), PH_W'(2), {PH_W{1'b1}}}));
endmodule

// File: tb/test_ssc_phase_rotator.sv
module test_ssc_phase_rotator;
  localparam int TDIV = 4;
  localparam int FW   = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spread_en;
  logic        order_sel;
  logic [23:0] slope_cfg;
  logic [15:0] half_cfg;
  logic [5:0]  phase_idx;
  logic        freq_falling;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit started  = 0;
  int wraps    = 0;

  always #4 clk = ~clk;

  ssc_phase_rotator #(.PH_W(6), .FRAC_W(FW), .CNT_W(16), .TICK_DIV(TDIV), .MAX_ORDER(2))
    i_ssc_phase_rotator (
      .clk (clk), .rst_n (rst_n), .spread_en (spread_en), .order_sel (order_sel),
      .slope_cfg (slope_cfg), .half_cfg (half_cfg),
      .phase_idx (phase_idx), .freq_falling (freq_falling));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model built from the requirements
  logic [23:0] m_ofs, m_a1, m_a2, m_s;
  int          m_pre, m_cnt, m_h;
  logic        m_dir, m_c2d, m_en_last, m_ord_last;
  logic [5:0]  m_ph;

  always @(posedge clk or negedge rst_n) begin : model
    logic [24:0] t1, t2;
    logic tk;
    int stp;
    if (!rst_n) begin
      m_ofs <= '0; m_a1 <= '0; m_a2 <= '0; m_s <= '0;
      m_pre <= 0; m_cnt <= 0; m_h <= 1;
      m_dir <= 1'b1; m_c2d <= 1'b0; m_ph <= '0;
      m_en_last <= 1'b0; m_ord_last <= 1'b0;
    end else begin
      tk  = spread_en && (m_pre == TDIV - 1);
      t1  = {1'b0, m_a1} + {1'b0, m_ofs};
      t2  = {1'b0, m_a2} + {1'b0, t1[23:0]};
      stp = order_sel ? (int'(t1[24]) + int'(t2[24]) - int'(m_c2d)) : int'(t1[24]);
      m_en_last  <= spread_en;
      m_ord_last <= order_sel;
      if (!spread_en) begin
        m_pre <= 0; m_a1 <= '0; m_a2 <= '0; m_c2d <= 1'b0;
        m_ofs <= '0; m_cnt <= 0; m_dir <= 1'b1;
        m_s <= slope_cfg; m_h <= (half_cfg == 0) ? 1 : int'(half_cfg);
      end else begin
        m_pre <= (m_pre == TDIV - 1) ? 0 : m_pre + 1;
        m_a1  <= t1[23:0];
        m_a2  <= order_sel ? t2[23:0] : 24'd0;
        m_c2d <= order_sel ? t2[24] : 1'b0;
        m_ph  <= m_ph + 6'(stp);
        if (tk) begin
          if (m_dir) begin
            m_cnt <= m_cnt + 1; m_ofs <= m_ofs + m_s;
            if (m_cnt + 1 >= m_h) m_dir <= 1'b0;
          end else begin
            m_cnt <= m_cnt - 1; m_ofs <= m_ofs - m_s;
            if (m_cnt == 1) m_dir <= 1'b1;
          end
        end
      end
    end
  end

  // per-cycle comparison and step-set monitor
  logic [5:0] prev_ph;
  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      check(phase_idx == m_ph, m_ord_last ? "R7 phase vs model" : "R6 phase vs model",
            phase_idx, m_ph);
      check(freq_falling == m_dir, "R4 direction vs model", freq_falling, m_dir);
      if (m_en_last) begin
        if (!m_ord_last)
          check((6'(phase_idx - prev_ph) inside {6'd0, 6'd1}), "R6 step set",
                6'(phase_idx - prev_ph), 1);
        else
          check((6'(phase_idx - prev_ph) inside {6'd0, 6'd1, 6'd2, 6'd63}), "R7 step set",
                6'(phase_idx - prev_ph), 1);
        if ((prev_ph == 6'd63 && phase_idx == 6'd0) || (prev_ph == 6'd0 && phase_idx == 6'd63))
          wraps++; // R8
      end
    end
    prev_ph = phase_idx;
  end

  task automatic idle_cfg(input logic [23:0] s, input logic [15:0] h, input logic ord);
    @(negedge clk);
    spread_en = 1'b0; slope_cfg = s; half_cfg = h; order_sel = ord;
    repeat (3) @(negedge clk);
  endtask

  // first-order closed form over whole periods (R5, R6, R3, R8)
  task automatic period_test(input logic [23:0] s, input int h, input int periods,
                             input string req);
    longint total;
    logic [5:0] p0, exp;
    idle_cfg(s, 16'(h), 1'b0);
    p0 = phase_idx;
    spread_en = 1'b1;
    repeat (2 * h * TDIV * periods) @(negedge clk);
    total = longint'(TDIV) * longint'(s) * longint'(h) * longint'(h) * longint'(periods);
    exp = 6'(longint'(p0) + (total >> FW));
    check(phase_idx == exp, req, phase_idx, exp);
    check(freq_falling == 1'b1, "R5 trough reached after full period", freq_falling, 1);
  endtask

  task automatic measure_fall(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (freq_falling && k < 100000);
  endtask
  task automatic measure_rise(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!freq_falling && k < 100000);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int k;
    logic [5:0] hold;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; spread_en = 1'b0; order_sel = 1'b0;
    slope_cfg = '0; half_cfg = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(phase_idx == 6'd0, "R1 phase after reset", phase_idx, 0);
    check(freq_falling == 1'b1, "R1 direction after reset", freq_falling, 1);
    started = 1;

    // R5/R6: one period, then R8: two periods (advance above 64 wraps)
    period_test(24'd200000, 30, 1, "R5 R6 one-period advance");
    period_test(24'd200000, 30, 2, "R8 two-period advance wraps");
    // R3: peak of 2^24-1 without wrapping
    period_test(24'hFFFFFF, 1, 1, "R3 full-scale peak advance");
    period_test(24'd1677721, 10, 3, "R3 near full-scale peak");

    // R4 apex timing with H=7
    idle_cfg(24'd1000, 16'd7, 1'b0);
    spread_en = 1'b1;
    measure_fall(k);
    check(k == 7 * TDIV, "R4 first half length", k, 7 * TDIV);
    // R9: reprogram mid-run; spacing must keep the captured H
    slope_cfg = 24'd999999; half_cfg = 16'd2;
    measure_rise(k);
    check(k == 7 * TDIV, "R9 falling half ignores new setting", k, 7 * TDIV);
    measure_fall(k);
    check(k == 7 * TDIV, "R9 next rising half ignores new setting", k, 7 * TDIV);
    // R4: H=0 acts as 1
    idle_cfg(24'd1000, 16'd0, 1'b0);
    spread_en = 1'b1;
    measure_fall(k);
    check(k == TDIV, "R4 zero half-period acts as one", k, TDIV);
    measure_rise(k);
    check(k == TDIV, "R4 zero half-period falling half", k, TDIV);

    // R2: drop enable in second order mid-ramp
    idle_cfg(24'd3000000, 16'd5, 1'b1);
    spread_en = 1'b1;
    repeat (27) @(negedge clk);
    hold = phase_idx;
    spread_en = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check(phase_idx == hold, "R2 phase holds while disabled", phase_idx, hold);
      check(freq_falling == 1'b1, "R2 direction restarts down", freq_falling, 1);
    end
    // R2: after re-enable, first fall comes after a full half from zero
    spread_en = 1'b1;
    measure_fall(k);
    check(k == 5 * TDIV, "R2 restart from zero offset", k, 5 * TDIV);

    // random segments against the model (R6, R7, R9)
    for (int seg = 0; seg < 40; seg++) begin
      int h, he, len;
      logic [23:0] s;
      h  = int'($urandom_range(0, 20));
      he = (h == 0) ? 1 : h;
      s  = 24'($urandom % (32'hFFFFFF / he + 1));
      idle_cfg(s, 16'(h), 1'($urandom_range(0, 1)));
      spread_en = 1'b1;
      len = int'($urandom_range(200, 700));
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if ($urandom_range(0, 99) == 0) order_sel = ~order_sel;
        if ($urandom_range(0, 49) == 0) begin
          slope_cfg = 24'($urandom); half_cfg = 16'($urandom);
        end
      end
    end
    check(wraps > 0, "R8 wraps observed", wraps, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule